// File: doc/BRIEF.md
# PCI Target Read Prefetch Controller

This block is the read half of a PCI target. A master's memory-read burst is answered from a small prefetch buffer, which the block fills by sending one-dword requests to an internal memory port. The block holds one read context at a time: the identity of the master that owns it and the address the owner will ask for next. When the buffer is nearly empty, it starts a refill. If a data phase cannot be finished in time, the block drops the master with a disconnect. The master may come back later and continue at the following address. While a refill for the owner is still in flight, every other read gets a retry.

The target side is a simplified, active-high form of the PCI target signals. `pci_frame` marks the transaction; its rising edge in the idle state is the address phase. A dword moves on each clock where `pci_trdy` and `pci_irdy` are both high. `pci_req_id` identifies the master that holds the bus. The memory side works as follows. A request carries a dword byte address and is accepted when `mem_req_valid` and `mem_req_ready` are both high. The memory returns responses in order, each marked by `mem_rsp_valid`, after any latency.

The target state machine has four states:

- **T_IDLE** waits for an address phase.
- **T_DATA** serves data phases.
- **T_RETRY** asserts stop before any transfer in the transaction.
- **T_DISC** asserts stop after at least one transfer.

Its transitions are:

- **claim**: T_IDLE to T_DATA, on a continuation or when a fresh context can be loaded.
- **refuse**: T_IDLE to T_RETRY, when the refill is busy.
- **finish**: T_DATA to T_IDLE, on the last transfer or when the master abandons the transaction.
- **timeout**: T_DATA to T_RETRY or T_DISC, when the stall limit is reached.
- **release**: T_RETRY or T_DISC to T_IDLE, once frame and irdy are both low.

The fetch state machine has three states:

- **F_IDLE**: no fetch activity.
- **F_FILL**: a batch of requests is being issued.
- **F_DRAIN**: waiting for the outstanding responses.

Its transitions are:

- **start**: F_IDLE to F_FILL, when buffered plus in-flight dwords are at or below the refill mark.
- **issued**: F_FILL to F_DRAIN, when the batch count reaches zero.
- **landed**: F_DRAIN to F_IDLE, when nothing is in flight.

Top module: `pci_rd_prefetch`

## Requirements
- R1: Only command code 4'b0110 (memory read) is claimed. Any other command leaves `pci_devsel` low and starts no memory request.
- R2: A claimed burst at address A returns, on each transfer k (counted from 0), the memory word at byte address A+4k.
- R3: A refill starts only when buffered plus in-flight dwords are at or below REFILL_AT (default 2). It requests the addresses following the last fetched dword. Buffered plus in-flight dwords never exceed BUF_DEPTH (default 8).
- R4: A data phase that stalls for LAT_LIMIT-2 (default 6) clocks with `pci_irdy` high ends with `pci_stop` high and `pci_trdy` low on the next clock. Every phase therefore ends within LAT_LIMIT clocks. `pci_stop` and `pci_trdy` are never high together.
- R5: While a refill is in progress, a read that is not a continuation gets `pci_stop` with no `pci_trdy` and transfers no data.
- R6: A read is a continuation when its id equals the owner's id and its address equals the owner's next address. It is served from the buffer, so its first `pci_trdy` comes with no stall clock when data is buffered.
- R7: A read that is not a continuation, arriving while no refill is in progress, discards the buffer and starts a new context at its own address. Its first data then waits for the memory.
- R8: After IDLE_TO (default 64) consecutive clocks idle with no refill in progress, the context is discarded, and a read at the old next address waits for the memory. A read within that window is still served at once.
- R9: After reset, `pci_devsel`, `pci_trdy`, `pci_stop` and `mem_req_valid` are low.
- R10: A memory request that is not accepted stays valid with an unchanged address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pci_frame | input | 1 | Transaction active (active high) |
| pci_irdy | input | 1 | Master ready (active high) |
| pci_addr | input | ADDR_W | Byte address, sampled in the address phase |
| pci_cmd | input | 4 | Bus command, sampled in the address phase |
| pci_req_id | input | ID_W | Identity of the master that holds the bus |
| pci_devsel | output | 1 | Transaction claimed |
| pci_trdy | output | 1 | Target ready, read data valid |
| pci_stop | output | 1 | Retry or disconnect request |
| pci_rdata | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | ADDR_W | Dword byte address requested |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | DATA_W | Memory response data |

## Verification
The assertions check several rules on every clock:

- stop and trdy are never high together;
- no stall run outlasts the latency limit;
- buffered plus in-flight dwords never exceed the buffer depth;
- an unaccepted memory request holds steady;
- a context is replaced only when nothing is in flight.

Some behaviour only scenarios can show:

- which reads count as continuations;
- that data is correct across disconnect-and-resume chains swept over burst length and memory latency;
- that other masters are refused while a refill is stuck;
- that a stale context is discarded, observed as the first-data stall count at the ports.

// File: rtl/pci_pf_pkg.sv
package pci_pf_pkg;

    typedef enum logic [1:0] {
        T_IDLE,
        T_DATA,
        T_RETRY,
        T_DISC
    } tgt_state_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_FILL,
        F_DRAIN
    } fet_state_e;

    localparam logic [3:0] CMD_MEM_READ = 4'b0110;

endpackage

// File: rtl/pf_buffer.sv
module pf_buffer #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int LW    = $clog2(DEPTH + 1),
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LW-1:0]     level,
    output logic              empty
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign empty = (level == '0);

endmodule

// File: rtl/pf_fetch.sv
module pf_fetch
    import pci_pf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DEPTH     = 8,
    parameter int REFILL_AT = 2,
    parameter int STEP      = 4,
    localparam int LW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LW-1:0]     level,
    input  logic              req_ready,
    input  logic              rsp_valid,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LW-1:0]     inflight,
    output logic              busy
);
    localparam logic [LW:0]   MARK    = (LW + 1)'(REFILL_AT);
    localparam logic [LW-1:0] FULL    = LW'(DEPTH);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

    fet_state_e      state, nxt;
    logic [LW:0]     held;
    logic [LW-1:0]   batch_left;
    logic            hs;

    assign held = {1'b0, level} + {1'b0, inflight};
    assign hs   = req_valid && req_ready;

    always_comb begin
        nxt = state;
        unique case (state)
            F_IDLE:  if (enable && !load && held <= MARK) nxt = F_FILL;
            F_FILL:  if (batch_left == '0)                nxt = F_DRAIN;
            F_DRAIN: if (inflight == '0)                  nxt = F_IDLE;
            default:                                      nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= F_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        req_valid = (state == F_FILL) && (batch_left != '0);
        busy      = (state != F_IDLE) || (inflight != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            batch_left <= '0;
            req_addr   <= '0;
            inflight   <= '0;
        end else begin
            if (state == F_IDLE && nxt == F_FILL) begin
                batch_left <= FULL - held[LW-1:0];
            end else if (hs) begin
                batch_left <= batch_left - 1'b1;
            end
            if (load) begin
                req_addr <= load_addr;
            end else if (hs) begin
                req_addr <= req_addr + INC;
            end
            unique case ({hs, rsp_valid})
                2'b10:   inflight <= inflight + 1'b1;
                2'b01:   inflight <= inflight - 1'b1;
                default: inflight <= inflight;
            endcase
        end
    end

endmodule

// File: rtl/pf_target.sv
module pf_target
    import pci_pf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 2,
    parameter int LAT_LIMIT = 8,
    parameter int IDLE_TO   = 64,
    parameter int STEP      = 4,
    localparam int STALL_MAX = LAT_LIMIT - 2,
    localparam int WW        = $clog2(LAT_LIMIT),
    localparam int IW        = $clog2(IDLE_TO + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame,
    input  logic              irdy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    input  logic [ID_W-1:0]   req_id,
    input  logic              buf_empty,
    input  logic              fetch_busy,
    output logic              devsel,
    output logic              trdy,
    output logic              stop,
    output logic              pop,
    output logic              ctx_load,
    output logic              ctx_drop,
    output logic              ctx_valid
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

    tgt_state_e        state, nxt;
    logic              frame_q;
    logic [WW-1:0]     stall_cnt;
    logic [IW-1:0]     idle_cnt;
    logic              moved;
    logic [ID_W-1:0]   own_id;
    logic [ADDR_W-1:0] next_addr;
    logic              start, is_read, cont, xfer;

    assign start   = (state == T_IDLE) && frame && !frame_q;
    assign is_read = (cmd == CMD_MEM_READ);
    assign cont    = ctx_valid && (req_id == own_id) && (addr == next_addr);
    assign xfer    = trdy && irdy;

    // output process
    always_comb begin
        devsel   = (state != T_IDLE);
        trdy     = (state == T_DATA) && !buf_empty;
        stop     = (state == T_RETRY) || (state == T_DISC);
        pop      = trdy && irdy;
        ctx_load = start && is_read && !cont && !fetch_busy;
        ctx_drop = (state == T_IDLE) && ctx_valid && !fetch_busy && !start &&
                   (idle_cnt == IW'(IDLE_TO - 1));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            T_IDLE: begin
                if (start && is_read) begin
                    nxt = (cont || !fetch_busy) ? T_DATA : T_RETRY;
                end
            end
            T_DATA: begin
                if (xfer && !frame) begin
                    nxt = T_IDLE;
                end else if (!frame && !irdy) begin
                    nxt = T_IDLE;
                end else if (irdy && buf_empty && stall_cnt == WW'(STALL_MAX - 1)) begin
                    nxt = moved ? T_DISC : T_RETRY;
                end
            end
            T_RETRY, T_DISC: begin
                if (!frame && !irdy) nxt = T_IDLE;
            end
            default: nxt = T_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q   <= 1'b0;
            stall_cnt <= '0;
            idle_cnt  <= '0;
            moved     <= 1'b0;
            own_id    <= '0;
            next_addr <= '0;
            ctx_valid <= 1'b0;
        end else begin
            frame_q <= frame;
            if (state != T_DATA || xfer) begin
                stall_cnt <= '0;
            end else if (irdy && buf_empty) begin
                stall_cnt <= stall_cnt + 1'b1;
            end
            if (state == T_IDLE) begin
                moved <= 1'b0;
            end else if (xfer) begin
                moved <= 1'b1;
            end
            if (state != T_IDLE || !ctx_valid || fetch_busy || start || ctx_drop) begin
                idle_cnt <= '0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
            if (ctx_load) begin
                ctx_valid <= 1'b1;
                own_id    <= req_id;
                next_addr <= addr;
            end else if (ctx_drop) begin
                ctx_valid <= 1'b0;
            end else if (xfer) begin
                next_addr <= next_addr + INC;
            end
        end
    end

endmodule

// File: rtl/pci_rd_prefetch.sv
module pci_rd_prefetch #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 2,
    parameter int BUF_DEPTH = 8,
    parameter int REFILL_AT = 2,
    parameter int LAT_LIMIT = 8,
    parameter int IDLE_TO   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pci_frame,
    input  logic              pci_irdy,
    input  logic [ADDR_W-1:0] pci_addr,
    input  logic [3:0]        pci_cmd,
    input  logic [ID_W-1:0]   pci_req_id,
    output logic              pci_devsel,
    output logic              pci_trdy,
    output logic              pci_stop,
    output logic [DATA_W-1:0] pci_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int LW   = $clog2(BUF_DEPTH + 1);
    localparam int STEP = DATA_W / 8;

    logic [LW-1:0] fifo_level;
    logic [LW-1:0] fetch_inflight;
    logic          fifo_empty;
    logic          fetch_busy;
    logic          pop;
    logic          ctx_load;
    logic          ctx_drop;
    logic          ctx_valid;

    pf_target #(
        .ADDR_W   (ADDR_W),
        .ID_W     (ID_W),
        .LAT_LIMIT(LAT_LIMIT),
        .IDLE_TO  (IDLE_TO),
        .STEP     (STEP)
    ) u_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame     (pci_frame),
        .irdy      (pci_irdy),
        .addr      (pci_addr),
        .cmd       (pci_cmd),
        .req_id    (pci_req_id),
        .buf_empty (fifo_empty),
        .fetch_busy(fetch_busy),
        .devsel    (pci_devsel),
        .trdy      (pci_trdy),
        .stop      (pci_stop),
        .pop       (pop),
        .ctx_load  (ctx_load),
        .ctx_drop  (ctx_drop),
        .ctx_valid (ctx_valid)
    );

    pf_fetch #(
        .ADDR_W   (ADDR_W),
        .DEPTH    (BUF_DEPTH),
        .REFILL_AT(REFILL_AT),
        .STEP     (STEP)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctx_valid),
        .load     (ctx_load),
        .load_addr(pci_addr),
        .level    (fifo_level),
        .req_ready(mem_req_ready),
        .rsp_valid(mem_rsp_valid),
        .req_valid(mem_req_valid),
        .req_addr (mem_req_addr),
        .inflight (fetch_inflight),
        .busy     (fetch_busy)
    );

    pf_buffer #(
        .DEPTH (BUF_DEPTH),
        .DATA_W(DATA_W)
    ) u_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ctx_load || ctx_drop),
        .push     (mem_rsp_valid),
        .push_data(mem_rsp_data),
        .pop      (pop),
        .head     (pci_rdata),
        .level    (fifo_level),
        .empty    (fifo_empty)
    );

endmodule

// File: rtl/pci_rd_prefetch_chk.sv
module pci_rd_prefetch_chk #(
    parameter int ADDR_W    = 32,
    parameter int BUF_DEPTH = 8,
    parameter int LAT_LIMIT = 8,
    localparam int LW       = $clog2(BUF_DEPTH + 1),
    localparam int CW       = $clog2(LAT_LIMIT) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pci_irdy,
    input logic              pci_devsel,
    input logic              pci_trdy,
    input logic              pci_stop,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [LW-1:0]     fifo_level,
    input logic [LW-1:0]     fetch_inflight,
    input logic              ctx_load
);
    logic [CW-1:0] stall_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_run <= '0;
        end else if (pci_devsel && pci_irdy && !pci_trdy && !pci_stop) begin
            stall_run <= stall_run + 1'b1;
        end else begin
            stall_run <= '0;
        end
    end

    a_r4_stop_excl_trdy: assert property (@(posedge clk) disable iff (!rst_n)
        !(pci_trdy && pci_stop));

    a_r4_trdy_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_trdy || pci_stop) |-> pci_devsel);

    a_r4_phase_limit: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run <= CW'(LAT_LIMIT - 2));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, fifo_level} + {1'b0, fetch_inflight}) <= (LW + 1)'(BUF_DEPTH));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |-> (fetch_inflight == '0));

endmodule

bind pci_rd_prefetch pci_rd_prefetch_chk #(
    .ADDR_W   (ADDR_W),
    .BUF_DEPTH(BUF_DEPTH),
    .LAT_LIMIT(LAT_LIMIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pci_irdy      (pci_irdy),
    .pci_devsel    (pci_devsel),
    .pci_trdy      (pci_trdy),
    .pci_stop      (pci_stop),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .fifo_level    (fifo_level),
    .fetch_inflight(fetch_inflight),
    .ctx_load      (ctx_load)
);

// File: tb/pci_rd_prefetch_tb.sv
`timescale 1ns/1ps
module pci_rd_prefetch_tb;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int ID_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pci_frame = 1'b0;
    logic              pci_irdy = 1'b0;
    logic [ADDR_W-1:0] pci_addr = '0;
    logic [3:0]        pci_cmd = '0;
    logic [ID_W-1:0]   pci_req_id = '0;
    logic              pci_devsel, pci_trdy, pci_stop;
    logic [DATA_W-1:0] pci_rdata;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    int  mem_lat  = 2;
    bit  ready_en = 1'b1;
    logic [ADDR_W-1:0] q_a [64];
    int  q_due [64];
    int  wp = 0;
    int  rp = 0;

    always #2.5 clk = ~clk;

    pci_rd_prefetch u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pci_frame    (pci_frame),
        .pci_irdy     (pci_irdy),
        .pci_addr     (pci_addr),
        .pci_cmd      (pci_cmd),
        .pci_req_id   (pci_req_id),
        .pci_devsel   (pci_devsel),
        .pci_trdy     (pci_trdy),
        .pci_stop     (pci_stop),
        .pci_rdata    (pci_rdata),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    function automatic logic [31:0] mdat(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    // memory model: in-order responses after mem_lat clocks
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid = 1'b0;
        end else begin
            mem_req_ready = ready_en;
            if (mem_req_valid && mem_req_ready) begin
                q_a[wp % 64]   = mem_req_addr;
                q_due[wp % 64] = cyc + mem_lat;
                wp++;
            end
            if (rp != wp && q_due[rp % 64] <= cyc) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mdat(q_a[rp % 64]);
                rp++;
            end else begin
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one read transaction; data of every transfer checked against R2
    task automatic rd(input logic [ID_W-1:0] id, input logic [31:0] a, input int n,
                      output int got, output bit stopped, output int first_wait,
                      output int max_wait, output int wstop);
        int w;
        @(negedge clk);
        pci_frame = 1'b1; pci_irdy = 1'b0; pci_cmd = 4'b0110;
        pci_addr = a; pci_req_id = id;
        @(negedge clk);
        pci_irdy = 1'b1;
        got = 0; stopped = 1'b0; first_wait = -1; max_wait = 0; wstop = 0; w = 0;
        for (int g = 0; g < 200; g++) begin
            if (pci_stop) begin
                stopped = 1'b1; wstop = w;
                pci_frame = 1'b0;
                @(negedge clk);
                pci_irdy = 1'b0;
                break;
            end else if (pci_trdy) begin
                chk("R2 data", pci_rdata, mdat(a + 32'(4 * got)));
                if (first_wait < 0) first_wait = w;
                if (w > max_wait) max_wait = w;
                w = 0;
                if (got + 1 == n) pci_frame = 1'b0;
                got++;
                if (got == n) begin
                    @(negedge clk);
                    pci_irdy = 1'b0;
                    break;
                end
            end else begin
                w++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int got, fw, mw, ws, total, tries;
        bit st;
        logic [31:0] held_a;

        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 outputs idle", {28'd0, pci_devsel, pci_trdy, pci_stop, mem_req_valid}, 32'd0);

        // R1 only memory read is claimed
        for (int c = 0; c < 16; c++) begin
            if (c != 6) begin
                pci_frame = 1'b1; pci_cmd = 4'(c); pci_addr = 32'h4000; pci_req_id = 0;
                @(negedge clk);
                pci_irdy = 1'b1;
                @(negedge clk);
                chk("R1 other cmd ignored", {30'd0, pci_devsel, mem_req_valid}, 32'd0);
                pci_frame = 1'b0;
                @(negedge clk);
                pci_irdy = 1'b0;
                @(negedge clk);
            end
        end

        // R2 R4 R7: sweep burst length and memory latency with resume after stop
        for (int li = 0; li < 3; li++) begin
            for (int n = 1; n <= 12; n++) begin
                logic [31:0] base;
                logic [ID_W-1:0] id;
                mem_lat = 1 + 3 * li;
                base = 32'h1000 * (li * 16 + n);
                id = ID_W'(n % 4);
                idle(30);
                total = 0; tries = 0;
                while (total < n && tries < 20) begin
                    rd(id, base + 32'(4 * total), n - total, got, st, fw, mw, ws);
                    chk("R4 stall within limit", (mw <= 6) ? 32'd1 : 32'd0, 32'd1);
                    if (st) chk("R4 stop after six stalls", 32'(ws), 32'd6);
                    total += got; tries++;
                end
                chk("R2 burst complete", 32'(total), 32'(n));
            end
        end

        // R6 R3: continuation from a full buffer, no refill above the mark
        mem_lat = 2;
        idle(30);
        rd(1, 32'h8000, 1, got, st, fw, mw, ws);
        chk("R7 new context waits for memory", (fw > 0) ? 32'd1 : 32'd0, 32'd1);
        idle(20);
        rd(1, 32'h8004, 2, got, st, fw, mw, ws);
        chk("R6 continuation no stall", 32'(fw), 32'd0);
        idle(5);
        chk("R3 no refill above mark", {31'd0, mem_req_valid}, 32'd0);

        // R4 R3 R10 R5: refill stuck, disconnect, others retried
        @(posedge clk);
        ready_en = 1'b0;
        rd(1, 32'h800C, 30, got, st, fw, mw, ws);
        chk("R4 disconnect data count", 32'(got), 32'd5);
        chk("R4 disconnect stop", {31'd0, st}, 32'd1);
        chk("R4 disconnect stall count", 32'(ws), 32'd6);
        chk("R3 refill requested", {31'd0, mem_req_valid}, 32'd1);
        chk("R3 refill address", mem_req_addr, 32'h8020);
        held_a = mem_req_addr;
        idle(3);
        chk("R10 request held", {31'd0, mem_req_valid}, 32'd1);
        chk("R10 address held", mem_req_addr, held_a);
        rd(2, 32'h9000, 4, got, st, fw, mw, ws);
        chk("R5 other master retried", {31'(got), st}, 32'd1);
        rd(1, 32'h9000, 4, got, st, fw, mw, ws);
        chk("R5 wrong address retried", {31'(got), st}, 32'd1);
        @(posedge clk);
        ready_en = 1'b1;
        idle(30);
        rd(1, 32'h8020, 4, got, st, fw, mw, ws);
        chk("R6 resume after disconnect", 32'(got), 32'd4);
        chk("R6 resume from buffer", 32'(fw), 32'd0);
        idle(30);

        // R7 stale context replaced
        rd(2, 32'hA000, 2, got, st, fw, mw, ws);
        chk("R7 other master new context", (fw > 0 && got == 2) ? 32'd1 : 32'd0, 32'd1);
        idle(30);
        rd(1, 32'h8030, 2, got, st, fw, mw, ws);
        chk("R7 old address refetched", (fw > 0 && got == 2) ? 32'd1 : 32'd0, 32'd1);
        idle(30);

        // R8 idle timeout
        rd(1, 32'h8038, 1, got, st, fw, mw, ws);
        chk("R6 continuation again", 32'(fw), 32'd0);
        idle(40);
        rd(1, 32'h803C, 1, got, st, fw, mw, ws);
        chk("R8 kept before timeout", 32'(fw), 32'd0);
        idle(80);
        rd(1, 32'h8040, 1, got, st, fw, mw, ws);
        chk("R8 discarded after timeout", (fw > 0 && got == 1) ? 32'd1 : 32'd0, 32'd1);

        idle(10);
        summary();
    end

endmodule